// File: doc/BRIEF.md
# Hop-Decrement Grid Configuration Router

This block steers configuration queries across a rectangular array of processing nodes. No node holds an absolute identity. A controller outside the array places a query at the west side of the south-west corner node. The query carries a relative destination made of a northing count (rows up) and an easting count (columns across). Each node moves the query one hop and lowers the relevant count by one. Eastward hops come first, then northward hops. The node that receives the query with both counts at zero recognises itself as the target and answers.

The answer returns hop by hop along the reverse of the path the query took. Each node keeps a small register that records which side the query arrived on. A node whose local self-check has failed shuts all of its ports. It forwards nothing and answers nothing, so it drops out of the array. When the controller gets no answer, the target is faulty, out of reach or outside the grid. Only one query is in flight at a time. The grid wrapper builds the array from one node module per position.

Top module: `hop_grid_top`

## Requirements
- R1: After reset, `rsp_pulse` stays low until a query is injected.
- R2: A node that receives a query with a nonzero easting passes it to its east neighbour with the easting lowered by one and the northing unchanged.
- R3: A node that receives a query with a zero easting and a nonzero northing passes it to its north neighbour with the northing lowered by one. The easting stays zero, and no count is ever lowered below zero.
- R4: The node that receives a query with both counts at zero answers. The answer appears on `rsp_pulse` as a one-cycle high exactly 2*(E+N) rising edges after the edge that samples `inj_valid`, where E and N are the injected easting and northing.
- R5: The answer retraces the arrival path through the recorded arrival side of each node. Exactly one pulse results per answered query.
- R6: The self-check bit for each node is `node_ok[row*COLS+col]`, and a low bit marks the node faulty. A faulty node ignores all inputs, forwards no query and emits no answer. A query whose target or path includes a faulty node therefore gets no answer. Faulty nodes off the path have no effect.
- R7: A query whose destination lies outside the grid (easting >= COLS or northing >= ROWS) gets no answer.
- R8: Queries enter at the west side of node row 0, column 0, and each count is FIELD_W = 8 bits wide. The destination 0/0 addresses the entry node itself, which answers on the same edge that samples the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | One-cycle query injection strobe |
| inj_north | input | FIELD_W | Rows up to the target |
| inj_east | input | FIELD_W | Columns across to the target |
| node_ok | input | ROWS*COLS | Self-check result per node, bit row*COLS+col, 1 = good |
| rsp_pulse | output | 1 | One-cycle answer from the addressed node |

## Verification
Each hop is one register stage in both directions. The answer to a query with counts E and N is due exactly 2*(E+N) edges after the injecting edge; for destination 0/0 it is due on that edge itself. On every injection the driver records the expected cycle number, or a no-answer marker, in a queue. The monitor samples `rsp_pulse` on falling edges and compares each pulse with the head of that queue. After a window longer than the round trip, the driver confirms that a no-answer entry was never consumed, so late, early, duplicated and missing answers are all reported.

// File: rtl/hop_pkg.sv
package hop_pkg;
   typedef enum logic {
      ARR_WEST  = 1'b0,
      ARR_SOUTH = 1'b1
   } arr_side_e;
endpackage

// File: rtl/hop_fwd.sv
module hop_fwd
   import hop_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               w_vld,
   input  logic [FIELD_W-1:0] w_east,
   input  logic [FIELD_W-1:0] w_north,
   input  logic               s_vld,
   input  logic [FIELD_W-1:0] s_east,
   input  logic [FIELD_W-1:0] s_north,
   output logic               e_vld,
   output logic               n_vld,
   output logic [FIELD_W-1:0] fwd_east,
   output logic [FIELD_W-1:0] fwd_north,
   output logic               hit,
   output arr_side_e          arr_dir
);
   initial assert (FIELD_W >= 1) else $error("hop_fwd: FIELD_W must be positive");

   function automatic logic [FIELD_W-1:0] dec_sat(input logic [FIELD_W-1:0] v);
      return (v == '0) ? v : v - 1'b1;
   endfunction

   logic               take;
   logic [FIELD_W-1:0] cur_east, cur_north;
   logic               east_nz, north_nz;
   arr_side_e          arr_q, arr_now;

   always_comb begin
      take     = en && (w_vld || s_vld);
      cur_east  = w_vld ? w_east  : s_east;
      cur_north = w_vld ? w_north : s_north;
      arr_now  = w_vld ? ARR_WEST : ARR_SOUTH;
      east_nz  = (cur_east  != '0);
      north_nz = (cur_north != '0);
      hit      = take && !east_nz && !north_nz;
      arr_dir  = take ? arr_now : arr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_vld     <= 1'b0;
         n_vld     <= 1'b0;
         fwd_east  <= '0;
         fwd_north <= '0;
         arr_q     <= ARR_WEST;
      end else begin
         e_vld <= take && east_nz;
         n_vld <= take && !east_nz && north_nz;
         if (take) begin
            arr_q     <= arr_now;
            fwd_east  <= dec_sat(cur_east);
            fwd_north <= east_nz ? cur_north : dec_sat(cur_north);
         end
      end
   end

   p_east_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (e_vld && $past(w_vld)) |-> (fwd_east == $past(w_east) - 1'b1 && fwd_north == $past(w_north)));

   p_north_zero_east_r3: assert property (@(posedge clk) disable iff (!rst_n)
      n_vld |-> (fwd_east == '0));

   p_fwd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({e_vld, n_vld}));
endmodule

// File: rtl/hop_reply.sv
module hop_reply
   import hop_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      hit,
   input  arr_side_e arr_dir,
   input  logic      rin_e,
   input  logic      rin_n,
   output logic      rout_w,
   output logic      rout_s
);
   logic go;

   always_comb go = en && (hit || rin_e || rin_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rout_w <= 1'b0;
         rout_s <= 1'b0;
      end else begin
         rout_w <= go && (arr_dir == ARR_WEST);
         rout_s <= go && (arr_dir == ARR_SOUTH);
      end
   end

   p_reply_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rout_w || rout_s) |-> $past(hit || rin_e || rin_n));
endmodule

// File: rtl/hop_node.sv
module hop_node
   import hop_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               self_ok,
   input  logic               w_vld,
   input  logic [FIELD_W-1:0] w_east,
   input  logic [FIELD_W-1:0] w_north,
   input  logic               s_vld,
   input  logic [FIELD_W-1:0] s_east,
   input  logic [FIELD_W-1:0] s_north,
   output logic               e_vld,
   output logic               n_vld,
   output logic [FIELD_W-1:0] fwd_east,
   output logic [FIELD_W-1:0] fwd_north,
   input  logic               rin_e,
   input  logic               rin_n,
   output logic               rout_w,
   output logic               rout_s
);
   logic      hit;
   arr_side_e arr_dir;

   hop_fwd #(.FIELD_W(FIELD_W)) u_fwd (
      .clk(clk), .rst_n(rst_n), .en(self_ok),
      .w_vld(w_vld), .w_east(w_east), .w_north(w_north),
      .s_vld(s_vld), .s_east(s_east), .s_north(s_north),
      .e_vld(e_vld), .n_vld(n_vld), .fwd_east(fwd_east), .fwd_north(fwd_north),
      .hit(hit), .arr_dir(arr_dir)
   );

   hop_reply u_rep (
      .clk(clk), .rst_n(rst_n), .en(self_ok), .hit(hit), .arr_dir(arr_dir),
      .rin_e(rin_e), .rin_n(rin_n), .rout_w(rout_w), .rout_s(rout_s)
   );

   p_bad_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!self_ok && $past(!self_ok)) |-> !(e_vld || n_vld || rout_w || rout_s));

   p_hit_no_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !(e_vld || n_vld));
endmodule

// File: rtl/hop_grid_top.sv
module hop_grid_top #(
   parameter int COLS    = 4,
   parameter int ROWS    = 4,
   parameter int FIELD_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 inj_valid,
   input  logic [FIELD_W-1:0]   inj_north,
   input  logic [FIELD_W-1:0]   inj_east,
   input  logic [ROWS*COLS-1:0] node_ok,
   output logic                 rsp_pulse
);
   localparam int NODES = ROWS * COLS;

   initial begin
      assert (COLS >= 1 && ROWS >= 1) else $error("hop_grid_top: grid must be non-empty");
      assert (NODES <= 1024) else $error("hop_grid_top: grid too large");
      assert (COLS <= (1 << FIELD_W) && ROWS <= (1 << FIELD_W))
         else $error("hop_grid_top: FIELD_W cannot address the grid");
   end

   logic               fe_vld    [ROWS][COLS];
   logic               fn_vld    [ROWS][COLS];
   logic [FIELD_W-1:0] f_east    [ROWS][COLS];
   logic [FIELD_W-1:0] f_north   [ROWS][COLS];
   logic               rw        [ROWS][COLS];
   logic               rs        [ROWS][COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic               wv, sv, re, rn;
         logic [FIELD_W-1:0] we, wn, se, sn;

         if (c == 0) begin : g_wedge
            if (r == 0) begin : g_entry
               assign wv = inj_valid;
               assign we = inj_east;
               assign wn = inj_north;
            end else begin : g_wall
               assign wv = 1'b0;
               assign we = '0;
               assign wn = '0;
            end
         end else begin : g_wlink
            assign wv = fe_vld[r][c-1];
            assign we = f_east[r][c-1];
            assign wn = f_north[r][c-1];
         end

         if (r == 0) begin : g_sedge
            assign sv = 1'b0;
            assign se = '0;
            assign sn = '0;
         end else begin : g_slink
            assign sv = fn_vld[r-1][c];
            assign se = f_east[r-1][c];
            assign sn = f_north[r-1][c];
         end

         if (c == COLS-1) begin : g_eedge
            assign re = 1'b0;
         end else begin : g_elink
            assign re = rw[r][c+1];
         end

         if (r == ROWS-1) begin : g_nedge
            assign rn = 1'b0;
         end else begin : g_nlink
            assign rn = rs[r+1][c];
         end

         hop_node #(.FIELD_W(FIELD_W)) u_node (
            .clk(clk), .rst_n(rst_n), .self_ok(node_ok[r*COLS+c]),
            .w_vld(wv), .w_east(we), .w_north(wn),
            .s_vld(sv), .s_east(se), .s_north(sn),
            .e_vld(fe_vld[r][c]), .n_vld(fn_vld[r][c]),
            .fwd_east(f_east[r][c]), .fwd_north(f_north[r][c]),
            .rin_e(re), .rin_n(rn),
            .rout_w(rw[r][c]), .rout_s(rs[r][c])
         );
      end
   end

   assign rsp_pulse = rw[0][0];

   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pulse |=> !rsp_pulse);

   p_entry_no_south_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rs[0][0]);
endmodule

// File: tb/hop_grid_top_test.sv
`timescale 1ns/1ps
module hop_grid_top_test;
   localparam int COLS = 4;
   localparam int ROWS = 4;
   localparam int FW   = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 inj_valid = 1'b0;
   logic [FW-1:0]        inj_north = '0;
   logic [FW-1:0]        inj_east  = '0;
   logic [ROWS*COLS-1:0] node_ok = '1;
   logic                 rsp_pulse;

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   bit    done = 0;
   int    exp_q[$];
   string cur_tag = "R1";

   hop_grid_top #(.COLS(COLS), .ROWS(ROWS), .FIELD_W(FW)) uut (
      .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_north(inj_north),
      .inj_east(inj_east), .node_ok(node_ok), .rsp_pulse(rsp_pulse)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic bit reachable(int e, int n);
      if (e >= COLS || n >= ROWS) return 0;
      for (int c = 0; c <= e; c++) if (!node_ok[c]) return 0;
      for (int r = 1; r <= n; r++) if (!node_ok[r*COLS+e]) return 0;
      return 1;
   endfunction

   // monitor: compares every pulse with the head of the queue
   always @(negedge clk) begin
      if (rst_n && rsp_pulse && !done) begin
         checks++;
         if (exp_q.size() == 0 || exp_q[0] < 0) begin
            errors++;
            $display("FAIL %s R5: unexpected pulse at cycle %0d, expected none", cur_tag, cyc);
         end else begin
            if (exp_q[0] != cyc) begin
               errors++;
               $display("FAIL %s R4: pulse at cycle %0d, expected %0d", cur_tag, cyc, exp_q[0]);
            end
            void'(exp_q.pop_front());
         end
      end
   end

   task automatic send(input int e, input int n, input string tag);
      int e0;
      @(negedge clk);
      cur_tag   = tag;
      inj_valid = 1'b1;
      inj_east  = FW'(e);
      inj_north = FW'(n);
      e0 = cyc + 1;
      exp_q.push_back(reachable(e, n) ? e0 + 2*(e+n) : -1);
      @(negedge clk);
      inj_valid = 1'b0;
      repeat (2*(e+n) + 6) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++;
         if (exp_q[0] < 0) begin
            void'(exp_q.pop_front());
         end else begin
            errors++;
            $display("FAIL %s: no pulse, actual none expected cycle %0d", tag, exp_q[0]);
            void'(exp_q.pop_front());
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: quiet after reset
      repeat (5) @(negedge clk) begin
         checks++;
         if (rsp_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_pulse=%b expected 0", rsp_pulse);
         end
      end
      send(0, 0, "R8");          // entry node itself
      send(3, 0, "R2");          // east only
      send(1, 0, "R2");
      send(0, 3, "R3");          // north only
      send(2, 1, "R3");
      send(3, 3, "R3");
      send(1, 2, "R4");
      send(2, 2, "R5");
      node_ok[2*COLS+2] = 1'b0;  // faulty target
      send(2, 2, "R6");
      node_ok = '1;
      node_ok[0*COLS+1] = 1'b0;  // faulty node on the path
      send(3, 1, "R6");
      node_ok = '1;
      node_ok[1*COLS+0] = 1'b0;  // faulty node off the path
      send(2, 2, "R6");
      node_ok = '1;
      node_ok[0] = 1'b0;         // faulty entry node
      send(0, 0, "R6");
      node_ok = '1;
      send(4, 0, "R7");
      send(0, 4, "R7");
      send(255, 255, "R7");
      send(3, 3, "R5");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule